// File: doc/BRIEF.md
# Serial Memory Power State Sequencer

This block decides when a serial memory slave may take commands and when its internal supply regulators run. It follows five states: a blocked interval after power comes up, normal standby, a timed descent into sleep, sleep itself, and a timed climb back out of sleep. All delays are counted on a free-running reference clock. The number of reference cycles per microsecond is a parameter, so each minimum delay is written in microseconds and turned into a cycle count at elaboration.

The command decoder sends a one-cycle strobe when it recognises the sleep or the wake opcode. The sequencer does not act on the strobe straight away. It stores the command and acts only when chip select (active low) rises to end that transaction. The sequencer also filters commands. In standby only the sleep request counts. In sleep only the wake request counts. While the startup, sleep-entry or wake-up timer runs, every strobe is dropped. If chip select falls during the wake-up interval, that transaction is ignored and the interval keeps running from where it was. A synchronous reset stands for loss of power: from any state, including sleep, the block restarts in the blocked startup interval and then settles in standby.

Top module: `pwr_state_seq`

## Requirements
- R1: While `rst` is high, and for STARTUP_US*CYC_PER_US reference cycles after the first rising edge with `rst` low, `accept_all` and `accept_wake` are 0 and `reg_en` is 1. `accept_all` rises at the next edge, which is STARTUP_US*CYC_PER_US+1 edges after release.
- R2: In standby `accept_all` is 1, `accept_wake` is 0 and `reg_en` is 1. A wake strobe in standby has no effect.
- R3: A sleep strobe in standby has no effect while `cs_n` stays low. `reg_en` falls no more than SYNC_STAGES+2 cycles after `cs_n` goes high.
- R4: During sleep entry all three outputs are 0. `accept_wake` rises exactly SLEEP_ENTRY_US*CYC_PER_US+1 cycles after `reg_en` falls, and `reg_en` stays 0.
- R5: In sleep `accept_wake` is 1, `reg_en` is 0 and `accept_all` is 0. A transaction that carries a sleep strobe, or no strobe at all, leaves those outputs unchanged.
- R6: A wake strobe in sleep, once `cs_n` rises, sets `reg_en` to 1 within SYNC_STAGES+2 cycles and clears `accept_wake`. `accept_all` rises exactly WAKE_US*CYC_PER_US+1 cycles after `reg_en` rises.
- R7: If `cs_n` falls during the wake-up interval, that transaction and any strobe in it are ignored. The interval is not restarted, so standby is reached in the same cycle as without the transaction.
- R8: Asserting `rst` while in sleep returns the block to the startup interval with `reg_en` 1, and then to standby. It does not return to sleep.
- R9: A sleep strobe and its `cs_n` rise, both during the startup interval, leave the block in standby once startup ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset; high means power is not good |
| cs_n | input | 1 | Chip select, active low; asynchronous, resynchronised inside |
| sleep_stb | input | 1 | One-cycle strobe: sleep opcode decoded |
| wake_stb | input | 1 | One-cycle strobe: wake opcode decoded |
| accept_all | output | 1 | Command engine may execute any command |
| accept_wake | output | 1 | Command engine may decode only the wake command |
| reg_en | output | 1 | Internal regulator enable |

## Verification
The assertions assume that a strobe arrives only in the middle of a transaction. `cs_n` must have been low for longer than the synchroniser depth before the strobe and must stay low for a few cycles after it. Otherwise a strobe could be stored against a transaction the block has not yet seen start. The assertions also assume that `rst` and both strobes are synchronous to `clk`. The bench meets these assumptions in every transaction: it holds `cs_n` low for four cycles before a strobe and for at least three cycles after it, and it drives every input on the falling clock edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        PS_STARTUP     = 3'd0,
        PS_STANDBY     = 3'd1,
        PS_SLEEP_ENTRY = 3'd2,
        PS_SLEEP       = 3'd3,
        PS_WAKING      = 3'd4
    } pwr_state_e;

    // Output bundle produced by each state
    typedef struct packed {
        logic accept_all;
        logic accept_wake;
        logic reg_en;
    } pwr_out_t;

    // Events issued by the command filter at the end of a transaction
    typedef struct packed {
        logic go_sleep;
        logic go_wake;
    } pwr_evt_t;

    function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned cyc_per_us);
        return us * cyc_per_us;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    function automatic pwr_out_t state_outputs(input pwr_state_e s);
        pwr_out_t o;
        o = '{accept_all: 1'b0, accept_wake: 1'b0, reg_en: 1'b1};
        case (s)
            PS_STANDBY:     o.accept_all  = 1'b1;
            PS_SLEEP_ENTRY: o.reg_en      = 1'b0;
            PS_SLEEP: begin
                o.reg_en      = 1'b0;
                o.accept_wake = 1'b1;
            end
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pwr_seq_cs_sync.sv
module pwr_seq_cs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic cs_high,
    output logic cs_rise,
    output logic cs_fall
);
    logic [STAGES-1:0] sync_q;
    logic              level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            level_d <= 1'b1;
        end else begin
            sync_q[0] <= cs_n;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            level_d <= sync_q[STAGES-1];
        end
    end

    assign cs_high = sync_q[STAGES-1];
    assign cs_rise = sync_q[STAGES-1] & ~level_d;
    assign cs_fall = ~sync_q[STAGES-1] & level_d;

    // R3: an end of transaction is seen only after chip select was low
    p_rise_after_low_r3: assert property (@(posedge clk) disable iff (rst)
        cs_rise |-> $past(!cs_high));

endmodule

// File: rtl/pwr_seq_cmd_filter.sv
module pwr_seq_cmd_filter
    import pwr_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_all,
    input  logic     accept_wake,
    input  logic     sleep_stb,
    input  logic     wake_stb,
    input  logic     cs_rise,
    input  logic     cs_fall,
    output pwr_evt_t evt
);
    logic pend_sleep_q;
    logic pend_wake_q;

    // A strobe is held until the transaction ends; a new transaction clears it
    always_ff @(posedge clk) begin
        if (rst || cs_fall || cs_rise) begin
            pend_sleep_q <= 1'b0;
            pend_wake_q  <= 1'b0;
        end else begin
            if (sleep_stb && accept_all)  pend_sleep_q <= 1'b1;
            if (wake_stb  && accept_wake) pend_wake_q  <= 1'b1;
        end
    end

    always_comb begin
        evt.go_sleep = cs_rise & pend_sleep_q;
        evt.go_wake  = cs_rise & pend_wake_q;
    end

    // R5: the two requests are never issued together
    p_single_event_r5: assert property (@(posedge clk) disable iff (rst)
        !(evt.go_sleep && evt.go_wake));

endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rst_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] remaining,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= rst_val;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign remaining = cnt_q;
    assign expired   = (cnt_q == '0);

    // R7: with no new load the count never rises
    p_no_rise_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_US     = 50,
    parameter int unsigned STARTUP_US     = 400,
    parameter int unsigned SLEEP_ENTRY_US = 3,
    parameter int unsigned WAKE_US        = 400,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sleep_stb,
    input  logic wake_stb,
    output logic accept_all,
    output logic accept_wake,
    output logic reg_en
);
    localparam int unsigned STARTUP_CYC = us_to_cyc(STARTUP_US, CYC_PER_US);
    localparam int unsigned ENTRY_CYC   = us_to_cyc(SLEEP_ENTRY_US, CYC_PER_US);
    localparam int unsigned WAKE_CYC    = us_to_cyc(WAKE_US, CYC_PER_US);
    localparam int unsigned MAX_CYC     = max3(STARTUP_CYC, ENTRY_CYC, WAKE_CYC);
    localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);
    localparam int unsigned DW          = CNT_W + 1;

    localparam logic [CNT_W-1:0] STARTUP_LD = CNT_W'(STARTUP_CYC);
    localparam logic [CNT_W-1:0] ENTRY_LD   = CNT_W'(ENTRY_CYC);
    localparam logic [CNT_W-1:0] WAKE_LD    = CNT_W'(WAKE_CYC);
    localparam logic [DW-1:0]    STARTUP_DW = DW'(STARTUP_CYC);
    localparam logic [DW-1:0]    ENTRY_DW   = DW'(ENTRY_CYC);
    localparam logic [DW-1:0]    WAKE_DW    = DW'(WAKE_CYC);

    pwr_state_e       state_q;
    pwr_state_e       state_nx;
    pwr_out_t         outs;
    pwr_evt_t         evt;
    logic             cs_high;
    logic             cs_rise;
    logic             cs_fall;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_left;
    logic             tmr_done;

    // Chip select resynchronisation and edge detection
    pwr_seq_cs_sync #(
        .STAGES (SYNC_STAGES)
    ) u_cs_sync (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .cs_high (cs_high),
        .cs_rise (cs_rise),
        .cs_fall (cs_fall)
    );

    // Command acceptance depends on the present state
    pwr_seq_cmd_filter u_filter (
        .clk         (clk),
        .rst         (rst),
        .accept_all  (outs.accept_all),
        .accept_wake (outs.accept_wake),
        .sleep_stb   (sleep_stb),
        .wake_stb    (wake_stb),
        .cs_rise     (cs_rise),
        .cs_fall     (cs_fall),
        .evt         (evt)
    );

    // One shared down-counter serves all three timed intervals
    pwr_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rst_val   (STARTUP_LD),
        .load      (tmr_load),
        .load_val  (tmr_val),
        .remaining (tmr_left),
        .expired   (tmr_done)
    );

    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            PS_STARTUP: begin
                if (tmr_done) state_nx = PS_STANDBY;
            end
            PS_STANDBY: begin
                if (evt.go_sleep) begin
                    state_nx = PS_SLEEP_ENTRY;
                    tmr_load = 1'b1;
                    tmr_val  = ENTRY_LD;
                end
            end
            PS_SLEEP_ENTRY: begin
                if (tmr_done) state_nx = PS_SLEEP;
            end
            PS_SLEEP: begin
                if (evt.go_wake) begin
                    state_nx = PS_WAKING;
                    tmr_load = 1'b1;
                    tmr_val  = WAKE_LD;
                end
            end
            PS_WAKING: begin
                if (tmr_done) state_nx = PS_STANDBY;
            end
            default: state_nx = PS_STARTUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_STARTUP;
        else     state_q <= state_nx;
    end

    assign outs        = state_outputs(state_q);
    assign accept_all  = outs.accept_all;
    assign accept_wake = outs.accept_wake;
    assign reg_en      = outs.reg_en;

    // Dwell counter: cycles spent in the current state, used only by checks
    logic [DW-1:0] dwell_q;
    always_ff @(posedge clk) begin
        if (rst || state_nx != state_q) dwell_q <= '0;
        else if (dwell_q != '1)         dwell_q <= dwell_q + 1'b1;
    end

    // R1: startup interval is never cut short
    p_startup_min_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_STARTUP && state_nx == PS_STANDBY) |-> (dwell_q >= STARTUP_DW));

    // R4: sleep entry lasts at least its minimum
    p_entry_min_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_SLEEP_ENTRY && state_nx == PS_SLEEP) |-> (dwell_q >= ENTRY_DW));

    // R6: wake-up lasts at least its minimum
    p_wake_min_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WAKING && state_nx == PS_STANDBY) |-> (dwell_q >= WAKE_DW));

    // R3: a sleep request can only come out of standby
    p_sleep_from_standby_r3: assert property (@(posedge clk) disable iff (rst)
        evt.go_sleep |-> (state_q == PS_STANDBY));

    // R5: a wake request can only come out of sleep
    p_wake_from_sleep_r5: assert property (@(posedge clk) disable iff (rst)
        evt.go_wake |-> (state_q == PS_SLEEP));

    // R5: sleep is left only toward wake-up
    p_sleep_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_SLEEP) |=> (state_q == PS_SLEEP || state_q == PS_WAKING));

    // R7: the wake-up count keeps falling whatever chip select does
    p_wake_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_WAKING && $past(state_q) == PS_WAKING) |-> (tmr_left == $past(tmr_left) - 1'b1));

    // R4: regulators go off only in response to a sleep request
    p_regoff_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(reg_en) |-> $past(evt.go_sleep));

endmodule

// File: tb/pwr_state_seq_tb.sv
module pwr_state_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int T_START    = 400 * CPU;
    localparam int T_ENTRY    = 3 * CPU;
    localparam int T_WAKE     = 400 * CPU;
    localparam int SYNC       = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sleep_stb = 1'b0;
    logic wake_stb = 1'b0;
    logic accept_all, accept_wake, reg_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_seq #(
        .CYC_PER_US     (CPU),
        .STARTUP_US     (400),
        .SLEEP_ENTRY_US (3),
        .WAKE_US        (400),
        .SYNC_STAGES    (SYNC)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sleep_stb   (sleep_stb),
        .wake_stb    (wake_stb),
        .accept_all  (accept_all),
        .accept_wake (accept_wake),
        .reg_en      (reg_en)
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_le(input int act, input int lim, input string req, input string what);
        checks++;
        if (act > lim) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected<=%0d", req, what, act, lim);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One transaction: 9 falling edges, cs_n high again after the last
    task automatic cs_txn(input logic do_sleep, input logic do_wake);
        step(); cs_n = 1'b0;
        repeat (4) step();
        sleep_stb = do_sleep; wake_stb = do_wake;
        step();
        sleep_stb = 1'b0; wake_stb = 1'b0;
        repeat (3) step();
        cs_n = 1'b1;
    endtask

    task automatic wait_reg(input logic lvl, output int n);
        n = 0;
        while (reg_en !== lvl && n < 40) begin
            step();
            n++;
        end
    endtask

    // R1 with R9 folded in: reset, startup timing, ignored request during startup
    task automatic t_reset_startup(input string req);
        rst = 1'b1;
        repeat (3) step();
        chk(accept_all, 1'b0, req, "accept_all in reset");
        chk(accept_wake, 1'b0, req, "accept_wake in reset");
        chk(reg_en, 1'b1, req, "reg_en in reset");
        rst = 1'b0;
        cs_txn(1'b1, 1'b0);              // R9: 9 edges used
        repeat (T_START - 9) step();
        chk(accept_all, 1'b0, "R1", "accept_all at last startup cycle");
        chk(reg_en, 1'b1, "R1", "reg_en during startup");
        step();
        chk(accept_all, 1'b1, "R1", "accept_all after startup");
        repeat (30) step();
        chk(reg_en, 1'b1, "R9", "sleep request during startup ignored");
        chk(accept_all, 1'b1, "R9", "still in standby");
    endtask

    task automatic t_standby_wake_ignored();
        cs_txn(1'b0, 1'b1);
        repeat (10) step();
        chk(accept_all, 1'b1, "R2", "accept_all after wake in standby");
        chk(accept_wake, 1'b0, "R2", "accept_wake in standby");
        chk(reg_en, 1'b1, "R2", "reg_en in standby");
    endtask

    task automatic t_enter_sleep();
        int n;
        step(); cs_n = 1'b0;
        repeat (4) step();
        sleep_stb = 1'b1;
        step();
        sleep_stb = 1'b0;
        repeat (6) step();
        chk(reg_en, 1'b1, "R3", "reg_en while cs_n still low");
        chk(accept_all, 1'b1, "R3", "accept_all while cs_n still low");
        cs_n = 1'b1;
        wait_reg(1'b0, n);
        chk(reg_en, 1'b0, "R3", "reg_en after cs_n rise");
        chk_le(n, SYNC + 2, "R3", "cycles from cs_n rise to reg_en low");
        chk(accept_all, 1'b0, "R4", "accept_all in sleep entry");
        chk(accept_wake, 1'b0, "R4", "accept_wake in sleep entry");
        repeat (T_ENTRY) step();
        chk(accept_wake, 1'b0, "R4", "accept_wake at last entry cycle");
        step();
        chk(accept_wake, 1'b1, "R4", "accept_wake after entry");
        chk(reg_en, 1'b0, "R4", "reg_en in sleep");
    endtask

    task automatic t_sleep_filter();
        cs_txn(1'b1, 1'b0);
        repeat (20) step();
        chk(reg_en, 1'b0, "R5", "reg_en after sleep cmd in sleep");
        chk(accept_wake, 1'b1, "R5", "accept_wake after sleep cmd in sleep");
        cs_txn(1'b0, 1'b0);
        repeat (20) step();
        chk(accept_all, 1'b0, "R5", "accept_all after empty txn in sleep");
        chk(reg_en, 1'b0, "R5", "reg_en after empty txn in sleep");
    endtask

    task automatic t_wake(input logic glitch);
        int n;
        int elapsed;
        string req;
        req = glitch ? "R7" : "R6";
        cs_txn(1'b0, 1'b1);
        wait_reg(1'b1, n);
        chk(reg_en, 1'b1, "R6", "reg_en after wake");
        chk_le(n, SYNC + 2, "R6", "cycles from cs_n rise to reg_en high");
        chk(accept_wake, 1'b0, "R6", "accept_wake during wake-up");
        elapsed = 0;
        if (glitch) begin
            repeat (20) step();
            cs_n = 1'b0;
            repeat (4) step();
            sleep_stb = 1'b1; wake_stb = 1'b1;
            step();
            sleep_stb = 1'b0; wake_stb = 1'b0;
            repeat (3) step();
            cs_n = 1'b1;
            elapsed = 28;
        end
        repeat (T_WAKE - elapsed) step();
        chk(accept_all, 1'b0, req, "accept_all at last wake-up cycle");
        step();
        chk(accept_all, 1'b1, req, "accept_all after wake-up");
        chk(reg_en, 1'b1, req, "reg_en in standby after wake-up");
        if (glitch) begin
            repeat (30) step();
            chk(reg_en, 1'b1, "R7", "sleep strobe during wake-up ignored");
            chk(accept_all, 1'b1, "R7", "still standby after ignored txn");
        end
    endtask

    initial begin
        t_reset_startup("R1");
        t_standby_wake_ignored();
        t_enter_sleep();
        t_sleep_filter();
        t_wake(1'b0);
        t_enter_sleep();
        t_wake(1'b1);
        t_enter_sleep();
        t_reset_startup("R8");
        chk(accept_wake, 1'b0, "R8", "not back in sleep after power loss");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule